// File: doc/BRIEF.md
# Register Rename Map with Ready Scoreboard

This block turns the architectural operands of one instruction per cycle into physical register numbers. Architectural tags arrive in a split space: integer tags sit below a floating-point base tag and floating-point tags sit at or above it. Both kinds are folded into one flat index that selects an entry of a single map table. Source operands read the table and a ready scoreboard. Each valid destination takes a fresh physical register from a FIFO free list, writes it into the table and clears its ready bit. The previous mapping is returned so that recovery logic elsewhere can undo the rename.

Recovery logic drives two side ports. The first writes a map entry back. The second pushes a physical register back onto the free list. A third port marks a physical register ready when its value has been produced. A request is held off (stall) when the free list holds fewer registers than the request has destinations, or when a map restore happens in the same cycle. A stalled request changes no state, and the same request can simply be presented again.

Top module: `rn_rename_core`

## Requirements
- R1: A tag below FP_BASE selects flat index equal to the tag; a tag t at or above FP_BASE selects flat index t - FP_BASE + N_INT_ARCH, so integer tag k and floating-point tag FP_BASE+k address different entries.
- R2: After reset, flat index f maps to physical register f, every physical register is ready, and the free list holds registers N_ARCH to N_PHYS-1 in ascending order.
- R3: For an accepted request, each source slot s reports on res_src_phys_o[s] the mapping held before the request's edge and on res_src_rdy_o[s] that register's ready bit, one clock edge after the request.
- R4: Each valid destination takes the next register from the head of the free list, lower destination slots first. It reports the new and the previous register, and the map holds the new register for any later request.
- R5: Sources of a request see the mappings from before its own destinations. A second destination naming the same architectural register as the first reports the first one's new register as its previous register.
- R6: A register given to a destination is marked not ready.
- R7: stall_o is high in the same cycle when req_vld_i is high and the free count is below the number of set bits of req_dst_vld_i. A stalled request changes neither the map nor the free list nor the scoreboard, and it yields no result. A request with no destinations is accepted even when the free list is empty.
- R8: A map restore writes rcv_map_phys_i into the entry chosen by rcv_map_tag_i, flattened as in R1. A request presented in the same cycle is stalled.
- R9: A freed register joins the tail of the free list. A freed register numbered POOL = N_INT_PHYS + N_FP_PHYS or above is also marked ready; a freed register below POOL keeps its ready bit.
- R10: wb_vld_i marks wb_phys_i ready from the next cycle on. A source read in the same cycle still sees the old bit.
- R11: res_vld_o is high exactly in the cycle after an accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_vld_i | input | 1 | Rename request present |
| req_src_i | input | N_SRC x TAG_W | Source architectural tags |
| req_dst_vld_i | input | N_DST | Destination slot used |
| req_dst_i | input | N_DST x TAG_W | Destination architectural tags |
| stall_o | output | 1 | Request not accepted this cycle |
| rcv_map_vld_i | input | 1 | Map restore strobe |
| rcv_map_tag_i | input | TAG_W | Architectural tag to restore |
| rcv_map_phys_i | input | PW | Physical register written back |
| rcv_free_vld_i | input | 1 | Free-list return strobe |
| rcv_free_phys_i | input | PW | Physical register returned |
| wb_vld_i | input | 1 | Result-produced strobe |
| wb_phys_i | input | PW | Physical register now holding a value |
| res_vld_o | output | 1 | Rename result valid |
| res_src_phys_o | output | N_SRC x PW | Source physical registers |
| res_src_rdy_o | output | N_SRC | Source ready bits |
| res_dst_vld_o | output | N_DST | Destination slot used |
| res_dst_new_o | output | N_DST x PW | Newly allocated registers |
| res_dst_old_o | output | N_DST x PW | Previous mappings |

## Verification
The stall decision is combinational, so the bench checks stall_o one nanosecond after it drives a request and before the next rising edge. Rename results are registered and are due exactly one edge after an accepted request. The driver pushes the expected result into a queue when it sees acceptance. The monitor samples on the following falling edge and flags both a result with nothing queued and a queued item with no result. Map, free-list and scoreboard changes from any port only become visible to a request in the next cycle. The reference model therefore reads its state before it applies the current cycle's writes.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // fold split int/fp tag space into one contiguous map index
  function automatic int unsigned flat_idx(input int unsigned tag, input int unsigned fp_base,
                                           input int unsigned n_int);
    return (tag < fp_base) ? tag : tag - fp_base + n_int;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int N_ARCH = 16,
  parameter int AW     = 4,
  parameter int PW     = 5,
  parameter int N_RD   = 2,
  parameter int N_WR   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N_RD-1:0][AW-1:0]   rd_idx_i,
  output logic [N_RD-1:0][PW-1:0]   rd_phys_o,
  input  logic [N_WR-1:0]           wr_en_i,
  input  logic [N_WR-1:0][AW-1:0]   wr_idx_i,
  input  logic [N_WR-1:0][PW-1:0]   wr_phys_i,
  output logic [N_WR-1:0][PW-1:0]   wr_old_o,
  input  logic                      rs_en_i,
  input  logic [AW-1:0]             rs_idx_i,
  input  logic [PW-1:0]             rs_phys_i
);
  logic [N_ARCH-1:0][PW-1:0] map_q;

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_phys_o[r] = map_q[rd_idx_i[r]];
  end

  // previous mapping, chained through earlier slots of the same request
  always_comb begin
    for (int j = 0; j < N_WR; j++) begin
      wr_old_o[j] = map_q[wr_idx_i[j]];
      for (int k = 0; k < j; k++) begin
        if (wr_en_i[k] && (wr_idx_i[k] == wr_idx_i[j])) wr_old_o[j] = wr_phys_i[k];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ARCH; i++) map_q[i] <= PW'(i);
    end else begin
      for (int j = 0; j < N_WR; j++) begin
        if (wr_en_i[j]) map_q[wr_idx_i[j]] <= wr_phys_i[j];
      end
      if (rs_en_i) map_q[rs_idx_i] <= rs_phys_i;
    end
  end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int DEPTH  = 28,
  parameter int N_INIT = 16,
  parameter int N_POP  = 2,
  parameter int PW     = 5,
  parameter int CW     = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CW-1:0]            pop_n_i,
  output logic [N_POP-1:0][PW-1:0] pop_data_o,
  input  logic                     push_i,
  input  logic [PW-1:0]            push_data_i,
  output logic [CW-1:0]            cnt_o
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int N_FREE = DEPTH - N_INIT;

  logic [DEPTH-1:0][PW-1:0] mem_q;
  logic [PTR_W-1:0]         head_q, tail_q;
  logic [CW-1:0]            cnt_q;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p, input int unsigned n);
    int unsigned s;
    s = 32'(p) + n;
    if (s >= DEPTH) s = s - DEPTH;
    return PTR_W'(s);
  endfunction

  for (genvar i = 0; i < N_POP; i++) begin : g_pop
    assign pop_data_o[i] = mem_q[adv(head_q, i)];
  end

  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= (i < N_FREE) ? PW'(i + N_INIT) : '0;
      head_q <= '0;
      tail_q <= PTR_W'(N_FREE % DEPTH);
      cnt_q  <= CW'(N_FREE);
    end else begin
      head_q <= adv(head_q, 32'(pop_n_i));
      if (push_i) begin
        mem_q[tail_q] <= push_data_i;
        tail_q        <= adv(tail_q, 1);
      end
      cnt_q <= cnt_q - pop_n_i + CW'(push_i);
    end
  end
endmodule

// File: rtl/rn_scoreboard.sv
module rn_scoreboard #(
  parameter int N_PHYS = 28,
  parameter int PW     = 5,
  parameter int N_RD   = 2,
  parameter int N_SET  = 2,
  parameter int N_CLR  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_RD-1:0][PW-1:0]  rd_idx_i,
  output logic [N_RD-1:0]          rd_o,
  input  logic [N_SET-1:0]         set_en_i,
  input  logic [N_SET-1:0][PW-1:0] set_idx_i,
  input  logic [N_CLR-1:0]         clr_en_i,
  input  logic [N_CLR-1:0][PW-1:0] clr_idx_i
);
  logic [N_PHYS-1:0] rdy_q, rdy_d;

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_o[r] = rdy_q[rd_idx_i[r]];
  end

  // clears from allocation win over sets
  always_comb begin
    rdy_d = rdy_q;
    for (int s = 0; s < N_SET; s++) if (set_en_i[s]) rdy_d[set_idx_i[s]] = 1'b1;
    for (int c = 0; c < N_CLR; c++) if (clr_en_i[c]) rdy_d[clr_idx_i[c]] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= '1;
    else         rdy_q <= rdy_d;
  end
endmodule

// File: rtl/rn_rename_core.sv
module rn_rename_core
  import rn_pkg::*;
#(
  parameter int N_INT_ARCH = 8,
  parameter int N_FP_ARCH  = 8,
  parameter int FP_BASE    = 32,
  parameter int N_INT_PHYS = 12,
  parameter int N_FP_PHYS  = 12,
  parameter int N_SPEC     = 4,
  parameter int N_SRC      = 2,
  parameter int N_DST      = 2,
  localparam int N_ARCH    = N_INT_ARCH + N_FP_ARCH,
  localparam int TAG_W     = $clog2(FP_BASE + N_FP_ARCH),
  localparam int POOL      = N_INT_PHYS + N_FP_PHYS,
  localparam int N_PHYS    = POOL + N_SPEC,
  localparam int PW        = $clog2(N_PHYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_vld_i,
  input  logic [N_SRC-1:0][TAG_W-1:0] req_src_i,
  input  logic [N_DST-1:0]            req_dst_vld_i,
  input  logic [N_DST-1:0][TAG_W-1:0] req_dst_i,
  output logic                        stall_o,
  input  logic                        rcv_map_vld_i,
  input  logic [TAG_W-1:0]            rcv_map_tag_i,
  input  logic [PW-1:0]               rcv_map_phys_i,
  input  logic                        rcv_free_vld_i,
  input  logic [PW-1:0]               rcv_free_phys_i,
  input  logic                        wb_vld_i,
  input  logic [PW-1:0]               wb_phys_i,
  output logic                        res_vld_o,
  output logic [N_SRC-1:0][PW-1:0]    res_src_phys_o,
  output logic [N_SRC-1:0]            res_src_rdy_o,
  output logic [N_DST-1:0]            res_dst_vld_o,
  output logic [N_DST-1:0][PW-1:0]    res_dst_new_o,
  output logic [N_DST-1:0][PW-1:0]    res_dst_old_o
);
  localparam int AW  = $clog2(N_ARCH);
  localparam int CW  = $clog2(N_PHYS + 1);
  localparam int OFW = (N_DST > 1) ? $clog2(N_DST) : 1;

  logic [N_SRC-1:0][AW-1:0] src_fl;
  logic [N_DST-1:0][AW-1:0] dst_fl;
  logic [AW-1:0]            rs_fl;
  logic [N_SRC-1:0][PW-1:0] src_phys;
  logic [N_SRC-1:0]         src_rdy;
  logic [N_DST-1:0][PW-1:0] pop_data, dst_new, dst_old;
  logic [N_DST-1:0]         dst_en;
  logic [CW-1:0]            free_cnt, need_cnt, pop_n;
  logic                     acc;
  logic                     free_special;

  always_comb begin
    for (int s = 0; s < N_SRC; s++)
      src_fl[s] = AW'(flat_idx(32'(req_src_i[s]), FP_BASE, N_INT_ARCH));
    for (int j = 0; j < N_DST; j++)
      dst_fl[j] = AW'(flat_idx(32'(req_dst_i[j]), FP_BASE, N_INT_ARCH));
    rs_fl = AW'(flat_idx(32'(rcv_map_tag_i), FP_BASE, N_INT_ARCH));
  end

  always_comb begin
    need_cnt = '0;
    for (int j = 0; j < N_DST; j++) need_cnt = need_cnt + CW'(req_dst_vld_i[j]);
  end

  // valid slots take consecutive free-list heads in slot order
  always_comb begin
    logic [OFW-1:0] run;
    run = '0;
    for (int j = 0; j < N_DST; j++) begin
      dst_new[j] = pop_data[run];
      if (req_dst_vld_i[j]) run = run + OFW'(1);
    end
  end

  assign stall_o      = req_vld_i & (rcv_map_vld_i | (free_cnt < need_cnt));
  assign acc          = req_vld_i & ~stall_o;
  assign dst_en       = req_dst_vld_i & {N_DST{acc}};
  assign pop_n        = acc ? need_cnt : '0;
  assign free_special = rcv_free_vld_i & (32'(rcv_free_phys_i) >= POOL);

  rn_map_table #(
    .N_ARCH(N_ARCH), .AW(AW), .PW(PW), .N_RD(N_SRC), .N_WR(N_DST)
  ) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (src_fl),
    .rd_phys_o (src_phys),
    .wr_en_i   (dst_en),
    .wr_idx_i  (dst_fl),
    .wr_phys_i (dst_new),
    .wr_old_o  (dst_old),
    .rs_en_i   (rcv_map_vld_i),
    .rs_idx_i  (rs_fl),
    .rs_phys_i (rcv_map_phys_i)
  );

  rn_free_list #(
    .DEPTH(N_PHYS), .N_INIT(N_ARCH), .N_POP(N_DST), .PW(PW), .CW(CW)
  ) u_fl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_n_i     (pop_n),
    .pop_data_o  (pop_data),
    .push_i      (rcv_free_vld_i),
    .push_data_i (rcv_free_phys_i),
    .cnt_o       (free_cnt)
  );

  rn_scoreboard #(
    .N_PHYS(N_PHYS), .PW(PW), .N_RD(N_SRC), .N_SET(2), .N_CLR(N_DST)
  ) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (src_phys),
    .rd_o      (src_rdy),
    .set_en_i  ({free_special, wb_vld_i}),
    .set_idx_i ({rcv_free_phys_i, wb_phys_i}),
    .clr_en_i  (dst_en),
    .clr_idx_i (dst_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_vld_o      <= 1'b0;
      res_src_phys_o <= '0;
      res_src_rdy_o  <= '0;
      res_dst_vld_o  <= '0;
      res_dst_new_o  <= '0;
      res_dst_old_o  <= '0;
    end else begin
      res_vld_o <= acc;
      if (acc) begin
        res_src_phys_o <= src_phys;
        res_src_rdy_o  <= src_rdy;
        res_dst_vld_o  <= req_dst_vld_i;
        res_dst_new_o  <= dst_new;
        res_dst_old_o  <= dst_old;
      end
    end
  end
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int N_DST = 2,
  parameter int PW    = 5,
  parameter int CW    = 5
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_vld_i,
  input logic                     rcv_map_vld_i,
  input logic                     stall_o,
  input logic                     res_vld_o,
  input logic [N_DST-1:0]         res_dst_vld_o,
  input logic [N_DST-1:0][PW-1:0] res_dst_new_o,
  input logic [N_DST-1:0][PW-1:0] res_dst_old_o,
  input logic [CW-1:0]            free_cnt,
  input logic [CW-1:0]            need_cnt
);
  a_r7_short_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && (need_cnt > free_cnt)) |-> stall_o);

  a_r7_room_accepts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && !rcv_map_vld_i && (need_cnt <= free_cnt)) |-> !stall_o);

  a_r8_restore_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && rcv_map_vld_i) |-> stall_o);

  a_r11_accept_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_vld_i && !stall_o) |=> res_vld_o);

  a_r11_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_vld_i && !stall_o) |=> !res_vld_o);

  for (genvar j = 0; j < N_DST; j++) begin : g_dst
    a_r4_new_not_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (res_vld_o && res_dst_vld_o[j]) |-> (res_dst_new_o[j] != res_dst_old_o[j]));
  end
endmodule

bind rn_rename_core rn_rename_chk #(.N_DST(N_DST), .PW(PW), .CW(CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_vld_i     (req_vld_i),
  .rcv_map_vld_i (rcv_map_vld_i),
  .stall_o       (stall_o),
  .res_vld_o     (res_vld_o),
  .res_dst_vld_o (res_dst_vld_o),
  .res_dst_new_o (res_dst_new_o),
  .res_dst_old_o (res_dst_old_o),
  .free_cnt      (free_cnt),
  .need_cnt      (need_cnt)
);

// File: tb/sim_rn_rename_core.sv
`timescale 1ns/1ps
module sim_rn_rename_core;
  localparam int TW = 6;
  localparam int PW = 5;
  localparam int NA = 16;
  localparam int NP = 28;
  localparam int POOL = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                 req_vld;
  logic [1:0][TW-1:0]   req_src, req_dst;
  logic [1:0]           req_dst_vld;
  logic                 stall;
  logic                 rs_vld, fr_vld, wb_vld;
  logic [TW-1:0]        rs_tag;
  logic [PW-1:0]        rs_phys, fr_phys, wb_phys;
  logic                 res_vld;
  logic [1:0][PW-1:0]   res_src_phys, res_dst_new, res_dst_old;
  logic [1:0]           res_src_rdy, res_dst_vld;

  rn_rename_core u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_vld_i(req_vld), .req_src_i(req_src), .req_dst_vld_i(req_dst_vld), .req_dst_i(req_dst),
    .stall_o(stall),
    .rcv_map_vld_i(rs_vld), .rcv_map_tag_i(rs_tag), .rcv_map_phys_i(rs_phys),
    .rcv_free_vld_i(fr_vld), .rcv_free_phys_i(fr_phys),
    .wb_vld_i(wb_vld), .wb_phys_i(wb_phys),
    .res_vld_o(res_vld), .res_src_phys_o(res_src_phys), .res_src_rdy_o(res_src_rdy),
    .res_dst_vld_o(res_dst_vld), .res_dst_new_o(res_dst_new), .res_dst_old_o(res_dst_old)
  );

  typedef struct packed {
    logic [1:0][PW-1:0] sp;
    logic [1:0]         sr;
    logic [1:0]         dv;
    logic [1:0][PW-1:0] dn;
    logic [1:0][PW-1:0] dold;
  } exp_t;

  exp_t  exp_q[$];
  exp_t  mon_e;
  int    map_m[NA];
  bit    rdy_m[NP];
  int    fl_m[$];
  int    total = 0;
  int    bad = 0;
  string phase = "R2 reset";

  function automatic int fl(input int t);
    if (t >= 32) return t - 32 + 8;
    return t;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] got, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", what, got, expv);
    end
  endtask

  task automatic step(input bit rq, input int s0, input int s1, input bit v0, input int d0,
                      input bit v1, input int d1, input bit rs = 0, input int rtag = 0,
                      input int rphys = 0, input bit fr = 0, input int fphys = 0,
                      input bit wb = 0, input int wphys = 0);
    exp_t e;
    int   need;
    bit   est;
    int   m2[NA];
    int   dd[2];
    bit   vv[2];
    int   alloc[$];
    @(negedge clk);
    req_vld = rq; req_src[0] = TW'(s0); req_src[1] = TW'(s1);
    req_dst_vld = {v1, v0}; req_dst[0] = TW'(d0); req_dst[1] = TW'(d1);
    rs_vld = rs; rs_tag = TW'(rtag); rs_phys = PW'(rphys);
    fr_vld = fr; fr_phys = PW'(fphys);
    wb_vld = wb; wb_phys = PW'(wphys);
    #1;
    need = int'(v0) + int'(v1);
    est  = rq && (rs || (need > fl_m.size()));
    chk(stall == est, {phase, " R7 R8 stall"}, 64'(stall), 64'(est));
    dd[0] = d0; dd[1] = d1; vv[0] = v0; vv[1] = v1;
    if (rq && !est) begin
      e = '0;
      e.sp[0] = PW'(map_m[fl(s0)]); e.sr[0] = rdy_m[map_m[fl(s0)]];
      e.sp[1] = PW'(map_m[fl(s1)]); e.sr[1] = rdy_m[map_m[fl(s1)]];
      e.dv = {v1, v0};
      m2 = map_m;
      for (int j = 0; j < 2; j++) begin
        if (vv[j]) begin
          int n;
          n = fl_m.pop_front();
          e.dold[j] = PW'(m2[fl(dd[j])]);
          e.dn[j]   = PW'(n);
          m2[fl(dd[j])] = n;
          alloc.push_back(n);
        end
      end
      exp_q.push_back(e);
      map_m = m2;
    end
    if (wb) rdy_m[wphys] = 1'b1;
    if (fr && fphys >= POOL) rdy_m[fphys] = 1'b1;
    foreach (alloc[k]) rdy_m[alloc[k]] = 1'b0;
    if (fr) fl_m.push_back(fphys);
    if (rs) map_m[fl(rtag)] = rphys;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_vld) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {phase, " R11 unexpected result"}, 64'd1, 64'd0);
        end else begin
          mon_e = exp_q.pop_front();
          chk((res_src_phys == mon_e.sp) && (res_src_rdy == mon_e.sr), {phase, " R3 sources"},
              64'({res_src_phys, res_src_rdy}), 64'({mon_e.sp, mon_e.sr}));
          chk(res_dst_vld == mon_e.dv, {phase, " R4 dst slots"}, 64'(res_dst_vld), 64'(mon_e.dv));
          for (int j = 0; j < 2; j++) begin
            if (mon_e.dv[j])
              chk((res_dst_new[j] == mon_e.dn[j]) && (res_dst_old[j] == mon_e.dold[j]),
                  {phase, " R4 R5 destination"},
                  64'({res_dst_new[j], res_dst_old[j]}), 64'({mon_e.dn[j], mon_e.dold[j]}));
          end
        end
      end else if (exp_q.size() != 0) begin
        chk(1'b0, {phase, " R11 missing result"}, 64'd0, 64'd1);
      end
    end
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog expired got=hang exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    req_vld = 0; req_src = '0; req_dst = '0; req_dst_vld = '0;
    rs_vld = 0; rs_tag = '0; rs_phys = '0; fr_vld = 0; fr_phys = '0; wb_vld = 0; wb_phys = '0;
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) rdy_m[i] = 1'b1;
    for (int i = NA; i < NP; i++) fl_m.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_vld == 1'b0, "R2 R11 reset result idle", 64'(res_vld), 64'd0);
    chk(stall == 1'b0, "R2 reset stall low", 64'(stall), 64'd0);

    phase = "R1 R2 reset map";
    for (int i = 0; i < 8; i++) step(1, i, 32 + i, 0, 0, 0, 0);

    phase = "R5 read before write";
    step(1, 3, 3, 1, 3, 0, 0);
    phase = "R6 new reg not ready";
    step(1, 3, 35, 0, 0, 0, 0);
    phase = "R10 writeback same cycle";
    step(1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, map_m[3]);
    phase = "R10 writeback visible";
    step(1, 3, 0, 0, 0, 0, 0);

    phase = "R5 two dsts same arch";
    step(1, 33, 33, 1, 33, 1, 33);
    step(1, 33, 3, 0, 0, 0, 0);

    phase = "R4 drain";
    step(1, 0, 1, 1, 0, 1, 1);
    step(1, 2, 4, 1, 2, 1, 4);
    step(1, 5, 6, 1, 5, 1, 6);
    step(1, 7, 32, 1, 7, 1, 32);
    phase = "R7 short list";
    step(1, 0, 0, 1, 34, 1, 35);
    step(1, 0, 0, 1, 34, 0, 0);
    step(1, 0, 0, 1, 35, 0, 0);
    phase = "R7 zero dst on empty list";
    step(1, 34, 32, 0, 0, 0, 0);

    phase = "R9 free special and plain";
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, map_m[6]);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, map_m[1]);
    step(1, 6, 1, 0, 0, 0, 0);

    phase = "R8 restore priority";
    step(1, 6, 1, 0, 0, 0, 0, 1, 6, 6);
    step(1, 6, 1, 0, 0, 0, 0, 1, 1, 1);
    step(1, 6, 1, 0, 0, 0, 0);

    phase = "R4 R9 fifo reuse";
    step(1, 0, 0, 1, 37, 0, 0);
    step(1, 37, 0, 0, 0, 0, 0);

    phase = "R4 wrap";
    for (int it = 0; it < 40; it++) begin
      int p;
      int q;
      p = map_m[fl(35)];
      q = fl_m[0];
      step(1, 35, 35, 1, 35, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 1, 35, p, 1, q);
    end
    step(1, 35, 3, 0, 0, 0, 0);

    phase = "R11 drain";
    repeat (4) idle();
    chk(exp_q.size() == 0, "R11 all results seen", 64'(exp_q.size()), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule